// File: doc/BRIEF.md
# SIMT Divergence Lane-Mask Stack

This block tracks which lanes of a 32-lane SIMD group are currently allowed to commit results while one instruction stream runs through nested, data-dependent branches. Every lane executes every instruction. The active mask produced here gates which lanes write back. The sequencer that walks the instruction stream supplies a per-lane predicate and one of four control operations on each clock.

Entering a divergent `if` saves the current mask on an internal stack and narrows the mask to the lanes whose predicate is true. At the `else` marker the mask flips to the lanes that were active before the branch but did not take it. At the join point the saved mask is restored. Nested regions stack up to a parameterised depth (8 by default). Pushing into a full stack, or popping or complementing an empty one, raises a one-cycle fault flag and leaves the mask untouched. A combinational flag reports an all-zero mask, so the sequencer can skip a path that no lane executes.

Top module: `simt_mask_stack`

## Requirements
- R1: After reset the active mask is all ones, the stack holds no entries, and both fault flags are low.
- R2: Operation code 1 (push) with fewer than DEPTH saved entries stores the current mask on the stack and sets the mask to the current mask AND the predicate. The result appears on the cycle after the clock edge that accepts the operation.
- R3: Operation code 2 (complement) with at least one saved entry sets the mask to the top saved mask AND the inverse of the current mask. The stack is not changed.
- R4: Operation code 3 (pop) with at least one saved entry sets the mask to the top saved mask and removes that entry.
- R5: Entries are restored in last-in, first-out order, with up to DEPTH (default 8) nested levels.
- R6: A push while DEPTH entries are saved raises `overflow` for exactly the following cycle and leaves the mask and the stack contents unchanged.
- R7: A pop or complement with no saved entry raises `underflow` for exactly the following cycle and leaves the mask unchanged.
- R8: `lanes_idle` is high exactly when the active mask is all zero, in the same cycle.
- R9: Operation code 0 (hold) keeps the mask and the stack unchanged, whatever the predicate.
- R10: A fault flag drops on the cycle after any operation that does not itself fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | 2 | 0 hold, 1 push, 2 complement, 3 pop |
| pred | input | LANES | Per-lane branch predicate, used by push |
| active_mask | output | LANES | Lanes allowed to commit |
| lanes_idle | output | 1 | Active mask is all zero |
| overflow | output | 1 | Previous push found the stack full |
| underflow | output | 1 | Previous pop or complement found the stack empty |

## Verification
The mask, the saved entries and both fault flags are registered. Each one therefore shows the effect of an operation one clock after the edge that accepts it, while `lanes_idle` follows the mask in the same cycle. The bench drives `op` and `pred` on a falling edge. It samples all four outputs on the next falling edge, after exactly one rising edge, and compares them with a reference stack built in the bench from the requirements. Overflow and underflow are checked for the cycle after the faulting operation and again after the following clean operation, to confirm that they last one cycle.

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       op,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] active_mask,
  output logic             lanes_idle,
  output logic             overflow,
  output logic             underflow
);
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [1:0] OP_PUSH = 2'd1;
  localparam logic [1:0] OP_COMP = 2'd2;
  localparam logic [1:0] OP_POP  = 2'd3;

  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] stk_q [DEPTH];
  logic [LVL_W-1:0] level_q;
  logic [IDX_W-1:0] top_idx, wr_idx;
  logic [LANES-1:0] top_mask;
  logic             full, empty;

  assign full     = (level_q == LVL_W'(DEPTH));
  assign empty    = (level_q == '0);
  assign top_idx  = IDX_W'(level_q - LVL_W'(1));
  assign wr_idx   = IDX_W'(level_q);
  assign top_mask = stk_q[top_idx];

  always_ff @(posedge clk) begin
    if (op == OP_PUSH && !full) stk_q[wr_idx] <= mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      level_q   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      unique case (op)
        OP_PUSH: begin
          if (full) overflow <= 1'b1;
          else begin
            mask_q  <= mask_q & pred;
            level_q <= level_q + LVL_W'(1);
          end
        end
        OP_COMP: begin
          if (empty) underflow <= 1'b1;
          else mask_q <= top_mask & ~mask_q;
        end
        OP_POP: begin
          if (empty) underflow <= 1'b1;
          else begin
            mask_q  <= top_mask;
            level_q <= level_q - LVL_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign active_mask = mask_q;
  assign lanes_idle  = ~|mask_q;
endmodule

// File: rtl/simt_mask_stack_chk.sv
module simt_mask_stack_chk #(
  parameter int LANES = 32,
  parameter int DEPTH = 8,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       op,
  input logic [LANES-1:0] pred,
  input logic [LANES-1:0] active_mask,
  input logic             overflow,
  input logic             underflow,
  input logic [LVL_W-1:0] level
);
  p_push_and_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd1 && level < LVL_W'(DEPTH)) |=>
      (active_mask == ($past(active_mask) & $past(pred)) && level == $past(level) + LVL_W'(1)));

  p_comp_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd2 && level != '0) |=>
      ((active_mask & $past(active_mask)) == '0 && $stable(level)));

  p_pop_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd3 && level != '0) |=> (level == $past(level) - LVL_W'(1)));

  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd1 && level == LVL_W'(DEPTH)) |=>
      (overflow && $stable(active_mask) && $stable(level)));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 2'd0 && op != 2'd1 && level == '0) |=>
      (underflow && $stable(active_mask)));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 2'd0) |=> ($stable(active_mask) && $stable(level) && !overflow && !underflow));

  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({overflow, underflow}));
endmodule

bind simt_mask_stack simt_mask_stack_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .pred(pred), .active_mask(active_mask),
  .overflow(overflow), .underflow(underflow), .level(level_q)
);

// File: tb/simt_mask_stack_test.sv
module simt_mask_stack_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 32;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       op = 2'd0;
  logic [LANES-1:0] pred = '0;
  logic [LANES-1:0] active_mask;
  logic             lanes_idle, overflow, underflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [LANES-1:0] m_mask;
  logic [LANES-1:0] m_stk [DEPTH];
  int               m_lvl;

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .op(op), .pred(pred),
    .active_mask(active_mask), .lanes_idle(lanes_idle),
    .overflow(overflow), .underflow(underflow)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [LANES-1:0] act, input logic [LANES-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] o, input logic [LANES-1:0] p, input string req);
    logic eo = 1'b0, eu = 1'b0;
    case (o)
      2'd1: if (m_lvl == DEPTH) eo = 1'b1;
            else begin m_stk[m_lvl] = m_mask; m_lvl++; m_mask = m_mask & p; end
      2'd2: if (m_lvl == 0) eu = 1'b1;
            else m_mask = m_stk[m_lvl-1] & ~m_mask;
      2'd3: if (m_lvl == 0) eu = 1'b1;
            else begin m_lvl--; m_mask = m_stk[m_lvl]; end
      default: ;
    endcase
    op = o; pred = p;
    @(negedge clk);
    check(req, "mask", active_mask, m_mask);
    check("R6", "overflow", {31'd0, overflow}, {31'd0, eo});
    check("R7", "underflow", {31'd0, underflow}, {31'd0, eu});
    check("R8", "idle", {31'd0, lanes_idle}, {31'd0, m_mask == '0});
    op = 2'd0; pred = '0;
  endtask

  task automatic t_reset;
    check("R1", "mask", active_mask, '1);
    check("R1", "overflow", {31'd0, overflow}, 32'd0);
    check("R1", "underflow", {31'd0, underflow}, 32'd0);
    step(2'd3, '0, "R1");
  endtask

  task automatic t_if_else;
    step(2'd1, 32'h0000_FFFF, "R2");
    step(2'd2, '0, "R3");
    step(2'd3, '0, "R4");
  endtask

  task automatic t_nested;
    step(2'd1, 32'hA5A5_A5A5, "R5");
    step(2'd1, 32'h0F0F_0F0F, "R5");
    step(2'd2, '0, "R5");
    step(2'd3, '0, "R5");
    step(2'd2, '0, "R5");
    step(2'd3, '0, "R5");
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH; i++) step(2'd1, ~(32'h3 << (3 * i)), "R5");
    step(2'd1, 32'h0, "R6");
    step(2'd0, 32'hFFFF_FFFF, "R10");
    for (int i = 0; i < DEPTH; i++) step(2'd3, '0, "R6");
    step(2'd3, '0, "R7");
    step(2'd0, '0, "R10");
  endtask

  task automatic t_underflow;
    step(2'd2, '0, "R7");
    step(2'd1, 32'h1234_5678, "R10");
    step(2'd3, '0, "R4");
  endtask

  task automatic t_hold;
    step(2'd1, 32'hFF00_00FF, "R2");
    step(2'd0, 32'h0000_0000, "R9");
    step(2'd0, 32'hFFFF_FFFF, "R9");
    step(2'd3, '0, "R4");
  endtask

  task automatic t_idle;
    step(2'd1, 32'h0, "R8");
    step(2'd2, '0, "R8");
    step(2'd1, 32'h0, "R8");
    step(2'd3, '0, "R8");
    step(2'd3, '0, "R8");
  endtask

  initial begin
    m_mask = '1;
    m_lvl  = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_if_else();
    t_nested();
    t_overflow();
    t_underflow();
    t_hold();
    t_idle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule